// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Output

A 16-bit timer/counter peripheral with one count register shared by three modes: auto-reload, capture, and serial baud-rate generation. An 8-bit control register selects the mode. Software reaches the control register, both count bytes and both capture/reload bytes through a byte-wide read/write port. The count advances either once per twelve oscillator-enable pulses or once per falling edge of an external count pin. A falling edge on an external trigger pin either snapshots the count into the capture/reload register or loads the count from it.

When either baud-select bit is set, the block feeds a serial port. The capture/reload select bit is then ignored, every rollover reloads the count, the overflow flag stays clear, and trigger edges are dropped. Each baud-tick output carries the timer's rollover pulse when its select bit is set, and otherwise passes through the overflow of a neighbouring timer. The interrupt request is the OR of the two sticky status flags.

Top module: `crt_timer`

## Requirements
- R1: After reset, all five registers read 0x00 and `irq` is 0. Register addresses are: 0 control, 1 count low, 2 count high, 3 capture/reload low, 4 capture/reload high.
- R2: The control bits are: 7 overflow flag, 6 trigger flag, 5 receive-baud select, 4 transmit-baud select, 3 trigger enable, 2 run, 1 source select (1 = count pin), 0 capture select. With run=1 and source select=0, the count advances by one for every 12th `osc_en` pulse since run was set.
- R3: With run=1 and source select=1, the count advances by one for each 1-to-0 change of `ext_cnt`, sampled on `clk`. A pin held low counts once. `osc_en` has no effect on the count in this mode.
- R4: With run=0, neither `osc_en`, `ext_cnt` nor `ext_trig` changes the count or the capture/reload register.
- R5: Capture mode is both baud selects 0 and capture select 1. A trigger falling edge with trigger enable set copies the count into the capture/reload register, leaves the count unchanged and sets the trigger flag. A rollover from 0xFFFF gives 0x0000 and sets the overflow flag.
- R6: Reload mode is both baud selects 0 and capture select 0. A rollover loads the count from the capture/reload register and sets the overflow flag. A trigger falling edge with trigger enable set also loads the count, and sets the trigger flag.
- R7: With trigger enable 0, a trigger falling edge changes neither the count, the capture/reload register nor the trigger flag.
- R8: With either baud select set, a rollover reloads the count regardless of capture select. The overflow flag is not set, and trigger edges cause no capture, no reload and no flag.
- R9: `rx_baud_tick` is high in the cycle in which the count rolls over when receive select is 1, and otherwise equals `alt_ovf`. `tx_baud_tick` behaves the same way under transmit select.
- R10: `irq` is the OR of the two flags. A flag, once set, stays set until software writes 0 to it.
- R11: A software write to a count byte in the same cycle as a hardware increment takes that byte from the write. A control write of 0 to a flag in the same cycle as a hardware set leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_en | input | 1 | One pulse per oscillator period, from a prescaler |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ext_cnt | input | 1 | External count pin |
| ext_trig | input | 1 | External capture/reload trigger pin |
| alt_ovf | input | 1 | Overflow pulse of the alternate timer |
| irq | output | 1 | Interrupt request |
| rx_baud_tick | output | 1 | Receive baud tick |
| tx_baud_tick | output | 1 | Transmit baud tick |

## Verification
The hardest cases to reach are collisions: a software write landing in the very cycle in which a detected pin edge increments the count or sets a flag. The bench places the pin's falling edge one clock ahead of the write strobe, because the edge detector adds exactly one register of delay. The single-cycle baud pulse is caught the same way, by sampling in the cycle after the count pin drops while the count sits at 0xFFFF. The timer-mode rate is checked without knowing the prescaler phase: the bench gates `osc_en` into bursts of known length after run is set.

// File: rtl/crt_pkg.sv
package crt_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_CTRL   = 3'd0;
    localparam logic [REG_AW-1:0] A_CNT_LO = 3'd1;
    localparam logic [REG_AW-1:0] A_RLD_LO = 3'd3;

    typedef struct packed {
        logic ovf_flag;
        logic trg_flag;
        logic rx_sel;
        logic tx_sel;
        logic trg_en;
        logic run;
        logic pin_src;
        logic cap_sel;
    } ctrl_t;
endpackage

// File: rtl/crt_prescale.sv
module crt_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q;
        tick  = 1'b0;
        if (clr) begin
            div_d = '0;
        end else if (en) begin
            tick  = (div_q == LAST);
            div_d = tick ? '0 : div_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R2
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= LAST);
endmodule

// File: rtl/crt_fall_det.sv
module crt_fall_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] fall
);
    typedef struct packed {
        logic [N-1:0] cur;
        logic [N-1:0] prev;
    } samp_t;

    samp_t s_d, s_q;

    always_comb begin
        s_d.cur  = din;
        s_d.prev = s_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign fall[i] = s_q.prev[i] & ~s_q.cur[i];

        // R3
        fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fall[i] |=> !fall[i]);
    end
endmodule

// File: rtl/crt_timer.sv
module crt_timer
    import crt_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int PRESCALE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ext_cnt,
    input  logic              ext_trig,
    input  logic              alt_ovf,
    output logic              irq,
    output logic              rx_baud_tick,
    output logic              tx_baud_tick
);
    localparam int NBYTE = 2;
    localparam int CNT_W = NBYTE * DATA_W;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  rld;
    } state_t;

    state_t     st_d, st_q;
    logic [1:0] pin_fall;
    logic       pre_tick;
    logic       baud, cap_mode, step, wrap, trig;
    logic       ctrl_wr, cnt_wr, rld_wr;

    crt_prescale #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (~st_q.ctrl.run),
        .en   (osc_en),
        .tick (pre_tick)
    );

    crt_fall_det #(.N(2)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ext_trig, ext_cnt}),
        .fall (pin_fall)
    );

    always_comb begin
        ctrl_wr = reg_wr && (reg_addr == A_CTRL);
        cnt_wr  = reg_wr && (reg_addr >= A_CNT_LO) && (reg_addr < A_CNT_LO + REG_AW'(NBYTE));
        rld_wr  = reg_wr && (reg_addr >= A_RLD_LO) && (reg_addr < A_RLD_LO + REG_AW'(NBYTE));
    end

    always_comb begin
        st_d     = st_q;
        baud     = st_q.ctrl.rx_sel | st_q.ctrl.tx_sel;
        cap_mode = ~baud & st_q.ctrl.cap_sel;
        step     = st_q.ctrl.run & (st_q.ctrl.pin_src ? pin_fall[0] : pre_tick);
        wrap     = step & (&st_q.cnt);
        trig     = st_q.ctrl.run & st_q.ctrl.trg_en & ~baud & pin_fall[1];

        if (step)
            st_d.cnt = wrap ? (cap_mode ? '0 : st_q.rld) : st_q.cnt + 1'b1;
        if (trig) begin
            if (cap_mode) st_d.rld = st_q.cnt;
            else          st_d.cnt = st_q.rld;
        end

        if (ctrl_wr)
            st_d.ctrl = ctrl_t'(reg_wdata[7:0]);
        for (int b = 0; b < NBYTE; b++) begin
            if (reg_wr && reg_addr == A_CNT_LO + REG_AW'(b))
                st_d.cnt[b*DATA_W +: DATA_W] = reg_wdata;
            if (reg_wr && reg_addr == A_RLD_LO + REG_AW'(b))
                st_d.rld[b*DATA_W +: DATA_W] = reg_wdata;
        end

        if (wrap & ~baud) st_d.ctrl.ovf_flag = 1'b1;
        if (trig)         st_d.ctrl.trg_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL) reg_rdata = DATA_W'(st_q.ctrl);
        for (int b = 0; b < NBYTE; b++) begin
            if (reg_addr == A_CNT_LO + REG_AW'(b)) reg_rdata = st_q.cnt[b*DATA_W +: DATA_W];
            if (reg_addr == A_RLD_LO + REG_AW'(b)) reg_rdata = st_q.rld[b*DATA_W +: DATA_W];
        end
    end

    assign irq          = st_q.ctrl.ovf_flag | st_q.ctrl.trg_flag;
    assign rx_baud_tick = st_q.ctrl.rx_sel ? wrap : alt_ovf;
    assign tx_baud_tick = st_q.ctrl.tx_sel ? wrap : alt_ovf;

    // R10
    ovf_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.ovf_flag && !ctrl_wr |=> st_q.ctrl.ovf_flag);

    // R10
    trg_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.trg_flag && !ctrl_wr |=> st_q.ctrl.trg_flag);

    // R4
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctrl.run && !cnt_wr && !rld_wr |=> $stable(st_q.cnt) && $stable(st_q.rld));

    // R7
    trig_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctrl.trg_en && !rld_wr |=> $stable(st_q.rld));

    // R8
    baud_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.rx_sel || st_q.ctrl.tx_sel) && !st_q.ctrl.ovf_flag && !ctrl_wr
        |=> !st_q.ctrl.ovf_flag);

    // R9
    baud_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.rx_sel && rx_baud_tick && !cnt_wr |=> st_q.cnt == $past(st_q.rld));
endmodule

// File: tb/crt_timer_tb.sv
`timescale 1ns/100ps
module crt_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ext_cnt = 1'b1;
    logic       ext_trig = 1'b1;
    logic       alt_ovf = 1'b0;
    logic       irq, rx_baud_tick, tx_baud_tick;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        int         src;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];
    event  sample_ev;

    always #2.5 clk = ~clk;

    crt_timer dut_i (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext_cnt(ext_cnt), .ext_trig(ext_trig), .alt_ovf(alt_ovf),
        .irq(irq), .rx_baud_tick(rx_baud_tick), .tx_baud_tick(tx_baud_tick)
    );

    // monitor: pops expected items and compares them against the ports
    initial begin
        forever begin
            @(sample_ev);
            while (sb.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb.pop_front();
                case (it.src)
                    0:       act = reg_rdata;
                    1:       act = {7'd0, irq};
                    2:       act = {7'd0, rx_baud_tick};
                    default: act = {7'd0, tx_baud_tick};
                endcase
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(int src, logic [7:0] e, string tag);
        item_t it;
        it.src = src; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic chk_reg(logic [2:0] a, logic [7:0] e, string tag);
        reg_addr = a;
        #1;
        push(0, e, tag);
        -> sample_ev;
        @(negedge clk);
    endtask

    task automatic chk_pin(int src, logic [7:0] e, string tag);
        #1;
        push(src, e, tag);
        -> sample_ev;
        @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_osc(int n);
        osc_en = 1'b1;
        repeat (n) @(negedge clk);
        osc_en = 1'b0;
    endtask

    task automatic cnt_fall();
        ext_cnt = 1'b0;
        repeat (2) @(negedge clk);
        ext_cnt = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic trig_fall();
        ext_trig = 1'b0;
        repeat (2) @(negedge clk);
        ext_trig = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        chk_reg(3'd0, 8'h00, "R1 ctrl");
        chk_reg(3'd1, 8'h00, "R1 cnt lo");
        chk_reg(3'd2, 8'h00, "R1 cnt hi");
        chk_reg(3'd3, 8'h00, "R1 rld lo");
        chk_reg(3'd4, 8'h00, "R1 rld hi");
        chk_pin(1, 8'h00, "R1 irq");
        alt_ovf = 1'b1;
        #1; push(2, 8'h01, "R9 rx passes alt"); push(3, 8'h01, "R9 tx passes alt"); -> sample_ev;
        @(negedge clk);
        alt_ovf = 1'b0;

        // R2 timer mode rate
        wr(3'd0, 8'h04);
        pulse_osc(36);
        chk_reg(3'd1, 8'h03, "R2 36 pulses");
        pulse_osc(11);
        chk_reg(3'd1, 8'h03, "R2 11 more pulses");
        pulse_osc(1);
        chk_reg(3'd1, 8'h04, "R2 12th pulse");

        // R4 stopped
        wr(3'd0, 8'h00);
        pulse_osc(24);
        cnt_fall();
        trig_fall();
        chk_reg(3'd1, 8'h04, "R4 stopped count");

        // R3 counter mode
        wr(3'd0, 8'h06);
        repeat (3) cnt_fall();
        chk_reg(3'd1, 8'h07, "R3 three edges");
        pulse_osc(24);
        chk_reg(3'd1, 8'h07, "R3 osc ignored");
        ext_cnt = 1'b0;
        repeat (6) @(negedge clk);
        ext_cnt = 1'b1;
        repeat (2) @(negedge clk);
        chk_reg(3'd1, 8'h08, "R3 held low counts once");

        // R6 auto-reload
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h34); wr(3'd4, 8'h12);
        wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
        wr(3'd0, 8'h06);
        cnt_fall();
        chk_reg(3'd1, 8'hFF, "R6 pre lo");
        chk_reg(3'd0, 8'h06, "R6 no flag yet");
        cnt_fall();
        chk_reg(3'd1, 8'h34, "R6 reload lo");
        chk_reg(3'd2, 8'h12, "R6 reload hi");
        chk_reg(3'd0, 8'h86, "R6 ovf flag");
        chk_pin(1, 8'h01, "R10 irq from ovf");
        wr(3'd0, 8'h0E);
        chk_pin(1, 8'h00, "R10 cleared by write");
        repeat (2) cnt_fall();
        chk_reg(3'd1, 8'h36, "R6 counting");
        trig_fall();
        chk_reg(3'd1, 8'h34, "R6 trigger reload");
        chk_reg(3'd0, 8'h4E, "R6 trg flag");
        chk_pin(1, 8'h01, "R10 irq from trg");
        repeat (10) @(negedge clk);
        chk_reg(3'd0, 8'h4E, "R10 flag sticky");

        // R7 trigger disabled
        wr(3'd0, 8'h06);
        cnt_fall();
        trig_fall();
        chk_reg(3'd1, 8'h35, "R7 no reload");
        chk_reg(3'd0, 8'h06, "R7 no flag");
        wr(3'd0, 8'h07);
        trig_fall();
        chk_reg(3'd3, 8'h34, "R7 no capture");

        // R5 capture
        wr(3'd0, 8'h0F);
        repeat (2) cnt_fall();
        trig_fall();
        chk_reg(3'd3, 8'h37, "R5 capture lo");
        chk_reg(3'd4, 8'h12, "R5 capture hi");
        chk_reg(3'd1, 8'h37, "R5 count kept");
        chk_reg(3'd0, 8'h4F, "R5 trg flag");
        wr(3'd0, 8'h0B);
        wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
        wr(3'd0, 8'h0F);
        cnt_fall();
        chk_reg(3'd1, 8'h00, "R5 wrap lo");
        chk_reg(3'd2, 8'h00, "R5 wrap hi");
        chk_reg(3'd0, 8'h8F, "R5 ovf flag");
        chk_reg(3'd3, 8'h37, "R5 rld kept on wrap");

        // R8 / R9 baud mode
        wr(3'd0, 8'h0B);
        wr(3'd3, 8'hF0); wr(3'd4, 8'hFF);
        wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
        wr(3'd0, 8'h2F);
        ext_cnt = 1'b0;
        @(negedge clk);
        #1; push(2, 8'h01, "R9 rx overflow tick"); push(3, 8'h00, "R9 tx follows alt"); -> sample_ev;
        @(negedge clk);
        ext_cnt = 1'b1;
        repeat (2) @(negedge clk);
        chk_reg(3'd1, 8'hF0, "R8 forced reload lo");
        chk_reg(3'd2, 8'hFF, "R8 forced reload hi");
        chk_reg(3'd0, 8'h2F, "R8 no ovf flag");
        chk_pin(1, 8'h00, "R8 no irq");
        cnt_fall();
        trig_fall();
        chk_reg(3'd3, 8'hF0, "R8 trigger ignored");
        chk_reg(3'd1, 8'hF1, "R8 count kept");
        chk_reg(3'd0, 8'h2F, "R8 no trg flag");
        wr(3'd0, 8'h1F);
        alt_ovf = 1'b1;
        #1; push(2, 8'h01, "R9 rx passes alt"); push(3, 8'h00, "R9 tx no overflow"); -> sample_ev;
        @(negedge clk);
        alt_ovf = 1'b0;

        // R11 write collisions
        wr(3'd0, 8'h02);
        wr(3'd1, 8'h10); wr(3'd2, 8'h00);
        wr(3'd0, 8'h06);
        ext_cnt = 1'b0;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h55; ext_cnt = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (2) @(negedge clk);
        chk_reg(3'd1, 8'h55, "R11 write beats increment");
        chk_reg(3'd2, 8'h00, "R11 hi byte");
        wr(3'd0, 8'h02);
        wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
        wr(3'd0, 8'h06);
        ext_cnt = 1'b0;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h06; ext_cnt = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (2) @(negedge clk);
        chk_reg(3'd0, 8'h86, "R11 hw flag set wins");

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule